// File: doc/BRIEF.md
# Instruction Exception Entry Sequencer

This block sits beside the decode stage of a small 32-bit CPU core. For every instruction that decode hands over, it looks at a three-bit instruction class, an 8-bit immediate and the instruction address. It also remembers whether that instruction occupies the slot behind a delayed branch. From these it decides whether the instruction raises an exception, and which one. There are three kinds: a software trap, an illegal instruction in a delay slot, and a general illegal instruction.

When an exception is raised, the block stalls the pipeline and runs the entry sequence over a single-port memory request bus. It stores the status word at the next lower stack word, then stores the return address below it. It then fetches the handler address from a vector table that sits at a base register. At the end it issues a fetch redirect to that handler address, and the redirect has no delay slot. The stack pointer copy in the core is updated through a write strobe after each push. The pipeline may not present another instruction while the block is busy, and anything presented during that time is ignored.

Top module: `instr_exc_entry`

## Requirements
- R1: A trap-class instruction (class code 4) accepted outside a delay slot starts a sequence. Its vector number is the 8-bit immediate, and the saved return address is the instruction address plus 2.
- R2: An instruction accepted right after a delayed-branch instruction (class code 2) that itself raised no exception is in a delay slot. Any other accepted instruction leaves the following instruction outside a slot.
- R3: In a delay slot, an undefined code or a PC-rewriting instruction starts a sequence with vector SLOT_VEC (default 6), and the saved address is that of the delayed branch. The undefined codes are 1, 5, 6 and 7. The PC-rewriting classes are 2 (delayed branch), 3 (conditional branch) and 4 (trap).
- R4: An undefined code (class 1, 5, 6 or 7) outside a delay slot starts a sequence with vector GEN_VEC (default 4), and the saved address is that of the undefined instruction.
- R5: The first memory write of a sequence stores the latched status word at SP-4. The second stores the saved return address at SP-8.
- R6: After both pushes, the block makes one read at VBR + 4 * vector.
- R7: The stack pointer write strobe pulses once per completed push, carrying SP-4 and then SP-8.
- R8: busy rises in the cycle after the accepting edge and drops in the cycle after the redirect. A plain instruction (class 0), or a conditional branch outside a slot, raises neither busy nor a memory request.
- R9: The redirect strobe is high for exactly one cycle, carrying the word returned by the vector read.
- R10: An instruction presented while busy is high is ignored.
- R11: A memory request holds its address, direction and write data stable until mem_ready is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dec_valid | input | 1 | Decode presents an instruction |
| dec_class | input | 3 | Instruction class code |
| dec_imm | input | 8 | Trap vector immediate |
| dec_pc | input | 32 | Address of the presented instruction |
| sr_in | input | 32 | Current status word |
| sp_in | input | 32 | Current stack pointer |
| vbr_in | input | 32 | Vector table base |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request completes this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |
| sp_wr_en | output | 1 | Stack pointer update strobe |
| sp_wr_data | output | 32 | New stack pointer value |
| busy | output | 1 | Pipeline stall |
| redir_valid | output | 1 | Fetch redirect strobe |
| redir_pc | output | 32 | Handler address |

## Verification
Traps are tried at a low and at the highest vector number. The highest value separates correct vector scaling from a truncated immediate. Undefined codes are tried with and without a preceding delayed branch, and also after a branch followed by a plain instruction. The vector number and the saved address then show whether slot tracking opens and closes the slot at the right time. Each PC-rewriting class is placed in a slot, so that the slot kind is not confused with the trap kind. A trap held on the decode port for the whole sequence shows whether the busy stall really masks input. Memory latency is varied so that the handshake hold is tested against fast and slow responses.

// File: rtl/iexc_pkg.sv
`timescale 1ns/1ps
package iexc_pkg;

   // instruction class codes from decode
   localparam logic [2:0] CLS_PLAIN = 3'd0;
   localparam logic [2:0] CLS_UNDEF = 3'd1;
   localparam logic [2:0] CLS_DBR   = 3'd2;
   localparam logic [2:0] CLS_CBR   = 3'd3;
   localparam logic [2:0] CLS_TRAP  = 3'd4;

   typedef enum logic [1:0] {
      EXK_NONE,
      EXK_TRAP,
      EXK_SLOT,
      EXK_GEN
   } exk_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_PUSH_SR,
      SQ_PUSH_PC,
      SQ_VEC,
      SQ_REDIR
   } sq_e;

   function automatic logic cls_undefined(input logic [2:0] c);
      return (c == CLS_UNDEF) || (c > CLS_TRAP);
   endfunction

   function automatic logic cls_rewrites_pc(input logic [2:0] c);
      return (c == CLS_DBR) || (c == CLS_CBR) || (c == CLS_TRAP);
   endfunction

endpackage

// File: rtl/iexc_slot_track.sv
`timescale 1ns/1ps
module iexc_slot_track #(
   parameter int AW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          accept,
   input  logic          is_dbr,
   input  logic          raise,
   input  logic [AW-1:0] pc,
   output logic          in_slot,
   output logic [AW-1:0] branch_pc
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_slot   <= 1'b0;
         branch_pc <= '0;
      end else if (accept) begin
         // a branch that itself faults opens no slot
         in_slot <= is_dbr && !raise;
         if (is_dbr && !raise) begin
            branch_pc <= pc;
         end
      end
   end

endmodule

// File: rtl/iexc_classify.sv
`timescale 1ns/1ps
module iexc_classify
   import iexc_pkg::*;
#(
   parameter int               AW       = 32,
   parameter int               VEC_W    = 8,
   parameter int               ILEN     = 2,
   parameter logic [VEC_W-1:0] SLOT_VEC = 6,
   parameter logic [VEC_W-1:0] GEN_VEC  = 4
) (
   input  logic             valid,
   input  logic [2:0]       cls,
   input  logic [VEC_W-1:0] imm,
   input  logic [AW-1:0]    pc,
   input  logic             in_slot,
   input  logic [AW-1:0]    branch_pc,
   output logic             raise,
   output logic [VEC_W-1:0] vec,
   output logic [AW-1:0]    save_pc
);

   localparam logic [AW-1:0] STEP = AW'(ILEN);

   exk_e kind;

   always_comb begin
      kind    = EXK_NONE;
      vec     = '0;
      save_pc = '0;
      if (valid) begin
         if (in_slot && (cls_undefined(cls) || cls_rewrites_pc(cls))) begin
            kind    = EXK_SLOT;
            vec     = SLOT_VEC;
            save_pc = branch_pc;
         end else if (cls_undefined(cls)) begin
            kind    = EXK_GEN;
            vec     = GEN_VEC;
            save_pc = pc;
         end else if (cls == CLS_TRAP) begin
            kind    = EXK_TRAP;
            vec     = imm;
            save_pc = pc + STEP;
         end
      end
   end

   assign raise = (kind != EXK_NONE);

endmodule

// File: rtl/iexc_sequencer.sv
`timescale 1ns/1ps
module iexc_sequencer
   import iexc_pkg::*;
#(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int VEC_W     = 8,
   parameter bit REDIR_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [VEC_W-1:0] vec,
   input  logic [AW-1:0]    save_pc,
   input  logic [DW-1:0]    sr_in,
   input  logic [AW-1:0]    sp_in,
   input  logic [AW-1:0]    vbr_in,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [DW-1:0]    mem_wdata,
   input  logic             mem_ready,
   input  logic [DW-1:0]    mem_rdata,
   output logic             sp_wr_en,
   output logic [AW-1:0]    sp_wr_data,
   output logic             busy,
   output logic             redir_valid,
   output logic [AW-1:0]    redir_pc
);

   localparam int            WBYTES = DW / 8;
   localparam int            WSH    = $clog2(WBYTES);
   localparam logic [AW-1:0] WORD1  = AW'(WBYTES);
   localparam logic [AW-1:0] WORD2  = AW'(2 * WBYTES);

   sq_e           state;
   logic [DW-1:0] sr_q;
   logic [AW-1:0] pc_q;
   logic [AW-1:0] sp_q;
   logic [AW-1:0] vaddr_q;
   logic          vec_done;

   assign vec_done = (state == SQ_VEC) && mem_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SQ_IDLE;
         sr_q    <= '0;
         pc_q    <= '0;
         sp_q    <= '0;
         vaddr_q <= '0;
      end else begin
         case (state)
            SQ_IDLE: begin
               if (start) begin
                  sr_q    <= sr_in;
                  pc_q    <= save_pc;
                  sp_q    <= sp_in;
                  vaddr_q <= vbr_in + (AW'(vec) << WSH);
                  state   <= SQ_PUSH_SR;
               end
            end
            SQ_PUSH_SR: if (mem_ready) state <= SQ_PUSH_PC;
            SQ_PUSH_PC: if (mem_ready) state <= SQ_VEC;
            SQ_VEC:     if (mem_ready) state <= REDIR_REG ? SQ_REDIR : SQ_IDLE;
            SQ_REDIR:   state <= SQ_IDLE;
            default:    state <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = '0;
      mem_wdata = '0;
      case (state)
         SQ_PUSH_SR: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = sp_q - WORD1;
            mem_wdata = sr_q;
         end
         SQ_PUSH_PC: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = sp_q - WORD2;
            mem_wdata = DW'(pc_q);
         end
         SQ_VEC: begin
            mem_req  = 1'b1;
            mem_addr = vaddr_q;
         end
         default: ;
      endcase
   end

   assign sp_wr_en   = mem_req && mem_we && mem_ready;
   assign sp_wr_data = mem_addr;
   assign busy       = (state != SQ_IDLE);

   generate
      if (REDIR_REG) begin : g_redir_reg
         logic [AW-1:0] hnd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hnd_q <= '0;
            end else if (vec_done) begin
               hnd_q <= mem_rdata[AW-1:0];
            end
         end
         assign redir_valid = (state == SQ_REDIR);
         assign redir_pc    = hnd_q;
      end else begin : g_redir_comb
         assign redir_valid = vec_done;
         assign redir_pc    = mem_rdata[AW-1:0];
      end
   endgenerate

endmodule

// File: rtl/instr_exc_entry.sv
`timescale 1ns/1ps
module instr_exc_entry
   import iexc_pkg::*;
#(
   parameter int               AW        = 32,
   parameter int               DW        = 32,
   parameter int               VEC_W     = 8,
   parameter int               ILEN      = 2,
   parameter logic [VEC_W-1:0] SLOT_VEC  = 6,
   parameter logic [VEC_W-1:0] GEN_VEC   = 4,
   parameter bit               REDIR_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dec_valid,
   input  logic [2:0]       dec_class,
   input  logic [VEC_W-1:0] dec_imm,
   input  logic [AW-1:0]    dec_pc,
   input  logic [DW-1:0]    sr_in,
   input  logic [AW-1:0]    sp_in,
   input  logic [AW-1:0]    vbr_in,
   output logic             mem_req,
   output logic             mem_we,
   output logic [AW-1:0]    mem_addr,
   output logic [DW-1:0]    mem_wdata,
   input  logic             mem_ready,
   input  logic [DW-1:0]    mem_rdata,
   output logic             sp_wr_en,
   output logic [AW-1:0]    sp_wr_data,
   output logic             busy,
   output logic             redir_valid,
   output logic [AW-1:0]    redir_pc
);

   generate
      if (AW > DW) begin : g_bad_aw
         $error("instr_exc_entry: AW must not exceed DW");
      end
      if ((DW % 8) != 0 || DW < 16) begin : g_bad_dw
         $error("instr_exc_entry: DW must be a byte multiple of at least 16");
      end
      if (VEC_W < 1 || VEC_W > AW - 4) begin : g_bad_vw
         $error("instr_exc_entry: VEC_W out of range");
      end
      if (ILEN < 1) begin : g_bad_ilen
         $error("instr_exc_entry: ILEN must be positive");
      end
   endgenerate

   logic             accept;
   logic             in_slot;
   logic [AW-1:0]    branch_pc;
   logic             raise;
   logic [VEC_W-1:0] vec;
   logic [AW-1:0]    save_pc;

   assign accept = dec_valid && !busy;

   iexc_slot_track #(.AW(AW)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .is_dbr    (dec_class == CLS_DBR),
      .raise     (raise),
      .pc        (dec_pc),
      .in_slot   (in_slot),
      .branch_pc (branch_pc)
   );

   iexc_classify #(
      .AW       (AW),
      .VEC_W    (VEC_W),
      .ILEN     (ILEN),
      .SLOT_VEC (SLOT_VEC),
      .GEN_VEC  (GEN_VEC)
   ) u_cls (
      .valid     (accept),
      .cls       (dec_class),
      .imm       (dec_imm),
      .pc        (dec_pc),
      .in_slot   (in_slot),
      .branch_pc (branch_pc),
      .raise     (raise),
      .vec       (vec),
      .save_pc   (save_pc)
   );

   iexc_sequencer #(
      .AW        (AW),
      .DW        (DW),
      .VEC_W     (VEC_W),
      .REDIR_REG (REDIR_REG)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (accept && raise),
      .vec         (vec),
      .save_pc     (save_pc),
      .sr_in       (sr_in),
      .sp_in       (sp_in),
      .vbr_in      (vbr_in),
      .mem_req     (mem_req),
      .mem_we      (mem_we),
      .mem_addr    (mem_addr),
      .mem_wdata   (mem_wdata),
      .mem_ready   (mem_ready),
      .mem_rdata   (mem_rdata),
      .sp_wr_en    (sp_wr_en),
      .sp_wr_data  (sp_wr_data),
      .busy        (busy),
      .redir_valid (redir_valid),
      .redir_pc    (redir_pc)
   );

endmodule

// File: rtl/instr_exc_entry_chk.sv
`timescale 1ns/1ps
module instr_exc_entry_chk #(
   parameter int AW = 32,
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          mem_req,
   input logic          mem_we,
   input logic [AW-1:0] mem_addr,
   input logic [DW-1:0] mem_wdata,
   input logic          mem_ready,
   input logic          sp_wr_en,
   input logic          busy,
   input logic          redir_valid
);

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R11

   AST_REDIR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |=> !redir_valid); // R9

   AST_REDIR_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |-> busy); // R8

   AST_BUSY_DROPS_AFTER_REDIR: assert property (@(posedge clk) disable iff (!rst_n)
      redir_valid |=> !busy); // R8

   AST_IDLE_NO_TRAFFIC: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mem_req && !sp_wr_en)); // R8

endmodule

bind instr_exc_entry instr_exc_entry_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .mem_req     (mem_req),
   .mem_we      (mem_we),
   .mem_addr    (mem_addr),
   .mem_wdata   (mem_wdata),
   .mem_ready   (mem_ready),
   .sp_wr_en    (sp_wr_en),
   .busy        (busy),
   .redir_valid (redir_valid)
);

// File: tb/tb_instr_exc_entry.sv
`timescale 1ns/1ps
module tb_instr_exc_entry;

   localparam logic [2:0] C_PLAIN = 3'd0;
   localparam logic [2:0] C_UNDEF = 3'd1;
   localparam logic [2:0] C_DBR   = 3'd2;
   localparam logic [2:0] C_CBR   = 3'd3;
   localparam logic [2:0] C_TRAP  = 3'd4;
   localparam logic [7:0] V_SLOT  = 8'd6;
   localparam logic [7:0] V_GEN   = 8'd4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        dec_valid = 1'b0;
   logic [2:0]  dec_class = '0;
   logic [7:0]  dec_imm = '0;
   logic [31:0] dec_pc = '0;
   logic [31:0] sr_in = '0;
   logic [31:0] sp_in = '0;
   logic [31:0] vbr_in = '0;
   logic        mem_ready = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        mem_req, mem_we, sp_wr_en, busy, redir_valid;
   logic [31:0] mem_addr, mem_wdata, sp_wr_data, redir_pc;

   int n_chk = 0;
   int n_fail = 0;

   logic [31:0] w_addr [4];
   logic [31:0] w_data [4];
   logic [31:0] spl [4];
   logic [31:0] r_addr;
   logic [31:0] rpc;
   int nw, nr, nsp, nredir, lat, wcnt;

   instr_exc_entry dut (
      .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_class(dec_class),
      .dec_imm(dec_imm), .dec_pc(dec_pc), .sr_in(sr_in), .sp_in(sp_in),
      .vbr_in(vbr_in), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
      .sp_wr_en(sp_wr_en), .sp_wr_data(sp_wr_data), .busy(busy),
      .redir_valid(redir_valid), .redir_pc(redir_pc)
   );

   initial forever #10 clk = ~clk;

   function automatic logic [31:0] handler_of(input logic [31:0] a);
      return 32'hC000_0000 ^ a;
   endfunction

   // memory responder
   initial begin
      wcnt = 0;
      forever begin
         @(negedge clk);
         if (mem_req && !mem_ready) begin
            if (wcnt >= lat) begin
               mem_ready = 1'b1;
               wcnt = 0;
               if (mem_we) begin
                  if (nw < 4) begin
                     w_addr[nw] = mem_addr;
                     w_data[nw] = mem_wdata;
                  end
                  nw++;
               end else begin
                  r_addr = mem_addr;
                  mem_rdata = handler_of(mem_addr);
                  nr++;
               end
            end else begin
               wcnt++;
            end
         end else begin
            mem_ready = 1'b0;
         end
      end
   end

   // output monitor, samples mid-way between edges
   initial forever begin
      @(negedge clk);
      #5;
      if (sp_wr_en) begin
         if (nsp < 4) spl[nsp] = sp_wr_data;
         nsp++;
      end
      if (redir_valid) begin
         nredir++;
         rpc = redir_pc;
      end
   end

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic clear_logs();
      nw = 0; nr = 0; nsp = 0; nredir = 0; r_addr = '0; rpc = '0;
   endtask

   task automatic issue(input logic [2:0] c, input logic [7:0] imm, input logic [31:0] pc);
      @(negedge clk);
      dec_valid = 1'b1; dec_class = c; dec_imm = imm; dec_pc = pc;
      @(negedge clk);
      dec_valid = 1'b0;
   endtask

   task automatic wait_redirect();
      for (int n = 0; n < 300 && nredir == 0; n++) @(negedge clk);
      repeat (3) @(negedge clk);
      #5;
   endtask

   task automatic run_exc(input string req, input logic [2:0] c, input logic [7:0] imm,
                          input logic [31:0] pc, input logic [31:0] sr, input logic [31:0] sp,
                          input logic [31:0] vbr, input logic [7:0] vec, input logic [31:0] save);
      logic [31:0] va;
      va = vbr + {22'd0, vec, 2'b00};
      clear_logs();
      sr_in = sr; sp_in = sp; vbr_in = vbr;
      issue(c, imm, pc);
      #5;
      chk({req, " R8"}, "busy after accept", 32'(busy), 32'd1);
      wait_redirect();
      chk({req, " R5"}, "push count", 32'(nw), 32'd2);
      chk({req, " R5"}, "first push addr", w_addr[0], sp - 32'd4);
      chk({req, " R5"}, "first push data", w_data[0], sr);
      chk({req, " R5"}, "second push addr", w_addr[1], sp - 32'd8);
      chk(req, "saved pc", w_data[1], save);
      chk({req, " R6"}, "vector reads", 32'(nr), 32'd1);
      chk({req, " R6"}, "vector addr", r_addr, va);
      chk({req, " R7"}, "sp strobes", 32'(nsp), 32'd2);
      chk({req, " R7"}, "sp first", spl[0], sp - 32'd4);
      chk({req, " R7"}, "sp second", spl[1], sp - 32'd8);
      chk({req, " R9"}, "redirect pulses", 32'(nredir), 32'd1);
      chk({req, " R9"}, "redirect pc", rpc, handler_of(va));
      chk({req, " R8"}, "busy released", 32'(busy), 32'd0);
   endtask

   task automatic t_reset();
      #5;
      chk("R8", "reset busy", 32'(busy), 32'd0);
      chk("R8", "reset mem_req", 32'(mem_req), 32'd0);
      chk("R9", "reset redir", 32'(redir_valid), 32'd0);
   endtask

   task automatic t_traps();
      lat = 0;
      run_exc("R1", C_TRAP, 8'h05, 32'h0000_1000, 32'h0000_00F0, 32'h0000_8000,
              32'h0000_4000, 8'h05, 32'h0000_1002);
      lat = 3; // R11 slow responses
      run_exc("R1", C_TRAP, 8'hFF, 32'h0000_1FFE, 32'hA5A5_0001, 32'h0001_0000,
              32'h0000_0000, 8'hFF, 32'h0000_2000);
      lat = 1;
   endtask

   task automatic t_general();
      run_exc("R4", C_UNDEF, 8'h00, 32'h0000_3000, 32'h0000_0011, 32'h0000_9000,
              32'h0000_4000, V_GEN, 32'h0000_3000);
      run_exc("R4", 3'd7, 8'h12, 32'h0000_3100, 32'h0000_0022, 32'h0000_9000,
              32'h0000_4000, V_GEN, 32'h0000_3100);
   endtask

   task automatic t_slot();
      logic [2:0] sc [4];
      sc[0] = C_UNDEF; sc[1] = C_CBR; sc[2] = C_TRAP; sc[3] = C_DBR;
      for (int i = 0; i < 4; i++) begin
         logic [31:0] bpc;
         bpc = 32'h0000_5000 + 32'(i * 16);
         issue(C_DBR, 8'h00, bpc);
         run_exc("R3", sc[i], 8'h21, bpc + 32'd2, 32'h0000_0300 + 32'(i),
                 32'h0000_A000, 32'h0000_0800, V_SLOT, bpc);
      end
   endtask

   task automatic t_slot_closes();
      issue(C_DBR, 8'h00, 32'h0000_6000);
      issue(C_PLAIN, 8'h00, 32'h0000_6002);
      run_exc("R2", C_UNDEF, 8'h00, 32'h0000_6004, 32'h0000_0044, 32'h0000_A000,
              32'h0000_0800, V_GEN, 32'h0000_6004);
   endtask

   task automatic t_no_exc();
      int seen;
      seen = 0;
      clear_logs();
      issue(C_PLAIN, 8'h00, 32'h0000_7000);
      issue(C_CBR, 8'h00, 32'h0000_7002);
      for (int n = 0; n < 6; n++) begin
         @(negedge clk);
         #5;
         if (busy || mem_req) seen++;
      end
      chk("R8", "quiet after plain and cond branch", 32'(seen), 32'd0);
   endtask

   task automatic t_ignore();
      int n;
      clear_logs();
      sr_in = 32'h0000_0055; sp_in = 32'h0000_B000; vbr_in = 32'h0000_0100;
      @(negedge clk);
      dec_valid = 1'b1; dec_class = C_TRAP; dec_imm = 8'h02; dec_pc = 32'h0000_2000;
      @(negedge clk);
      dec_imm = 8'h33; dec_pc = 32'h0000_3000;
      n = 0;
      while (n < 300) begin
         @(negedge clk);
         #5;
         n++;
         if (redir_valid) break;
      end
      dec_valid = 1'b0;
      repeat (10) @(negedge clk);
      #5;
      chk("R10", "pushes while held", 32'(nw), 32'd2);
      chk("R10", "saved pc of first trap", w_data[1], 32'h0000_2002);
      chk("R10", "vector reads while held", 32'(nr), 32'd1);
      chk("R10", "vector addr of first trap", r_addr, 32'h0000_0108);
      chk("R10", "redirects while held", 32'(nredir), 32'd1);
   endtask

   initial begin
      #(20 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      lat = 1;
      clear_logs();
      repeat (3) @(negedge clk);
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_traps();
      t_general();
      t_slot();
      t_slot_closes();
      t_no_exc();
      t_ignore();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

endmodule